// File: doc/BRIEF.md
# Burst-Capable On-Chip Memory Slave

This block is a word-organised on-chip RAM that answers an AXI4 master through its five channels. Reads are taken in freely. Each accepted read address is expanded into a run of data beats, one per cycle, and each beat is placed with its tag and end-of-burst marker into a response queue that feeds the R channel. Writes are handled one burst at a time. The address phase fixes the starting byte, the transaction tag, the number of beats and the bytes per beat. Data beats then land byte by byte under their strobes, and each finished burst leaves one completion in a small queue for the B channel.

Incoming addresses are made relative to a base parameter and then folded onto the memory size, which is a power of two, so any address maps somewhere in the array. Only incrementing bursts are modelled, and both response codes are always OKAY. A one-cycle error pulse flags a write burst whose final beat arrives without WLAST.

Top module: `axi_mem_slave`

## Requirements
- R1: A read burst with length field L and tag T returns L+1 beats on R, all with r_id = T, with r_last = 1 on the final beat only. While no earlier read is still being expanded and the queue has room, single-beat read addresses are accepted on consecutive cycles.
- R2: The first read beat comes from the word that contains the start byte, so the low address bits below the word size are ignored. Each later beat reads the next word up.
- R3: aw_ready and w_ready are never high together. w_ready is high exactly while a write burst is open. aw_ready is high when no burst is open and the completion queue is not full.
- R4: A write beat at byte offset o within its word, with beat size s = 2^aw_size bytes, updates byte lane b only when w_strb[b] = 1 and o <= b < o+s. The next beat's address is the current one plus s.
- R5: A write burst closes after aw_len+1 accepted W beats and pushes its aw_id into the completion queue. If w_last is 0 on that closing beat, wr_last_err is high during that beat's handshake cycle.
- R6: r_resp and b_resp are always 0 (OKAY). r_valid and b_valid are high while their queue holds an entry. An entry leaves only on a valid-and-ready handshake, so a stalled output keeps its values. Responses leave in the order they were queued.
- R7: The parameter BASE_ADDR is subtracted from every address, and the result is taken modulo MEM_BYTES. Accesses past the top of memory, within a burst or through an aliased address, land at the bottom.
- R8: ar_ready is low while the read queue holds more than RQ_DEPTH - 2^LEN_W beats, and while an earlier burst is still being expanded. No queued beat is ever lost.
- R9: While the read queue is empty, r_valid is 0 and r_data, r_id and r_last read as zero. While the completion queue is empty, b_valid and b_id read as zero.
- R10: After reset both queues are empty, no write burst is open, and aw_ready and ar_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_addr | input | ADDR_W | Read start byte address |
| ar_id | input | ID_W | Read tag |
| ar_len | input | LEN_W | Read beats minus one |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| aw_addr | input | ADDR_W | Write start byte address |
| aw_id | input | ID_W | Write tag |
| aw_len | input | LEN_W | Write beats minus one |
| aw_size | input | 3 | Log2 of bytes per write beat |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | DATA_W | Write data, byte lane b on bits 8b+7..8b |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Final write beat marker |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken |
| r_data | output | DATA_W | Read data |
| r_id | output | ID_W | Read tag |
| r_resp | output | 2 | Read response, always 0 |
| r_last | output | 1 | Final read beat marker |
| b_valid | output | 1 | Write completion valid |
| b_ready | input | 1 | Write completion taken |
| b_id | output | ID_W | Write tag of the completed burst |
| b_resp | output | 2 | Write response, always 0 |
| wr_last_err | output | 1 | Closing write beat arrived without w_last |

## Verification
The first beat of a read is queued at the same edge that accepts its address, so r_valid is visible one half-cycle later. Beat k is queued k edges after acceptance. Draining therefore starts at the first falling edge after the handshake, pops one beat per cycle, and never gets ahead of the queue. A W beat writes the memory and, if it closes the burst, queues its completion at its accepting edge. b_valid and the new contents are checked from the next falling edge on. wr_last_err and the ready outputs depend only on state and current inputs, so they are sampled one time unit after the inputs change at a falling edge, before the clock rises.

// File: rtl/axi_mem_pkg.sv
package axi_mem_pkg;
  localparam int          SIZE_W    = 3;
  localparam logic [1:0]  RESP_OKAY = 2'b00;
endpackage

// File: rtl/axi_mem_fifo.sv
module axi_mem_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = push ? step(wp_q) : wp_q;
    rp_n  = pop  ? step(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp_q] <= push_data;
  end

  assign head  = slots[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/axi_mem_rd_gen.sv
module axi_mem_rd_gen #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 4,
  parameter int WIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WIDX_W-1:0] start_widx,
  input  logic [ID_W-1:0]   start_id,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              beat_valid,
  output logic [WIDX_W-1:0] beat_widx,
  output logic [ID_W-1:0]   beat_id,
  output logic              beat_last
);
  logic              busy_q, busy_n;
  logic [WIDX_W-1:0] widx_q, widx_n;
  logic [ID_W-1:0]   id_q, id_n;
  logic [LEN_W-1:0]  rem_q, rem_n;

  always_comb begin
    busy_n     = busy_q;
    widx_n     = widx_q;
    id_n       = id_q;
    rem_n      = rem_q;
    beat_valid = 1'b0;
    beat_widx  = widx_q;
    beat_id    = id_q;
    beat_last  = 1'b0;
    if (busy_q) begin
      beat_valid = 1'b1;
      beat_last  = (rem_q == LEN_W'(1));
      rem_n      = rem_q - 1'b1;
      widx_n     = widx_q + 1'b1;
      busy_n     = (rem_q != LEN_W'(1));
    end else if (start) begin
      beat_valid = 1'b1;
      beat_widx  = start_widx;
      beat_id    = start_id;
      beat_last  = (start_len == '0);
      rem_n      = start_len;
      widx_n     = start_widx + 1'b1;
      id_n       = start_id;
      busy_n     = (start_len != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      widx_q <= '0;
      id_q   <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_n;
      widx_q <= widx_n;
      id_q   <= id_n;
      rem_q  <= rem_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/axi_mem_wr_ctrl.sv
module axi_mem_wr_ctrl
  import axi_mem_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4,
  parameter int OFS_W = 10,
  parameter int NB    = 4,
  localparam int WB   = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_fire,
  input  logic [OFS_W-1:0]  aw_ofs,
  input  logic [ID_W-1:0]   aw_tag,
  input  logic [LEN_W-1:0]  aw_beats_m1,
  input  logic [SIZE_W-1:0] aw_lg_size,
  input  logic              w_fire,
  input  logic              w_end,
  output logic              busy,
  output logic [OFS_W-WB-1:0] cur_widx,
  output logic [NB-1:0]     beat_mask,
  output logic              done,
  output logic [ID_W-1:0]   done_id,
  output logic              last_err
);
  logic             busy_q, busy_n;
  logic [OFS_W-1:0] addr_q, addr_n;
  logic [ID_W-1:0]  id_q, id_n;
  logic [LEN_W:0]   cnt_q, cnt_n;
  logic [7:0]       size_q, size_n;
  logic [8:0]       lane_lo, lane_hi;

  always_comb begin
    lane_lo = 9'(addr_q[WB-1:0]);
    lane_hi = lane_lo + 9'(size_q);
    for (int i = 0; i < NB; i++)
      beat_mask[i] = (9'(i) >= lane_lo) && (9'(i) < lane_hi);
  end

  always_comb begin
    busy_n = busy_q;
    addr_n = addr_q;
    id_n   = id_q;
    cnt_n  = cnt_q;
    size_n = size_q;
    if (aw_fire) begin
      busy_n = 1'b1;
      addr_n = aw_ofs;
      id_n   = aw_tag;
      cnt_n  = {1'b0, aw_beats_m1} + 1'b1;
      size_n = 8'(1) << aw_lg_size;
    end else if (w_fire) begin
      addr_n = addr_q + OFS_W'(size_q);
      cnt_n  = cnt_q - 1'b1;
      if (cnt_q == (LEN_W+1)'(1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      id_q   <= '0;
      cnt_q  <= '0;
      size_q <= '0;
    end else begin
      busy_q <= busy_n;
      addr_q <= addr_n;
      id_q   <= id_n;
      cnt_q  <= cnt_n;
      size_q <= size_n;
    end
  end

  assign busy     = busy_q;
  assign cur_widx = addr_q[OFS_W-1:WB];
  assign done     = w_fire && (cnt_q == (LEN_W+1)'(1));
  assign done_id  = id_q;
  assign last_err = done && !w_end;
endmodule

// File: rtl/axi_mem_slave.sv
module axi_mem_slave
  import axi_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int LEN_W     = 4,
  parameter int MEM_BYTES = 1024,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int RQ_DEPTH  = 32,
  parameter int BQ_DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ar_valid,
  output logic                ar_ready,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic [ID_W-1:0]     ar_id,
  input  logic [LEN_W-1:0]    ar_len,
  input  logic                aw_valid,
  output logic                aw_ready,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [ID_W-1:0]     aw_id,
  input  logic [LEN_W-1:0]    aw_len,
  input  logic [SIZE_W-1:0]   aw_size,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  output logic                r_valid,
  input  logic                r_ready,
  output logic [DATA_W-1:0]   r_data,
  output logic [ID_W-1:0]     r_id,
  output logic [1:0]          r_resp,
  output logic                r_last,
  output logic                b_valid,
  input  logic                b_ready,
  output logic [ID_W-1:0]     b_id,
  output logic [1:0]          b_resp,
  output logic                wr_last_err
);
  localparam int NB        = DATA_W / 8;
  localparam int WB        = $clog2(NB);
  localparam int OFS_W     = $clog2(MEM_BYTES);
  localparam int WIDX_W    = OFS_W - WB;
  localparam int WORDS     = MEM_BYTES / NB;
  localparam int MAX_BEATS = 1 << LEN_W;
  localparam int RQ_W      = ID_W + DATA_W + 1;
  localparam int RQ_CW     = $clog2(RQ_DEPTH + 1);
  localparam int BQ_CW     = $clog2(BQ_DEPTH + 1);
  localparam logic [RQ_CW-1:0] RQ_LIMIT = RQ_CW'(RQ_DEPTH - MAX_BEATS);

  logic [DATA_W-1:0] mem_q [WORDS];

  logic              ar_fire, aw_fire, w_fire, r_pop, b_pop;
  logic [WIDX_W-1:0] ar_widx;
  logic [OFS_W-1:0]  aw_ofs;

  logic              rd_busy, beat_valid, beat_last;
  logic [WIDX_W-1:0] beat_widx;
  logic [ID_W-1:0]   beat_id;

  logic              wr_busy, wr_done, wr_err;
  logic [WIDX_W-1:0] wr_widx;
  logic [NB-1:0]     wr_mask, lane_en;
  logic [ID_W-1:0]   wr_done_id;

  logic [RQ_W-1:0]   rq_in, rq_head;
  logic              rq_empty, rq_full;
  logic [RQ_CW-1:0]  rq_count;
  logic [ID_W-1:0]   bq_head;
  logic              bq_empty, bq_full;
  logic [BQ_CW-1:0]  bq_count;

  assign ar_widx = WIDX_W'((ar_addr - BASE_ADDR) >> WB);
  assign aw_ofs  = OFS_W'(aw_addr - BASE_ADDR);

  assign ar_ready = !rd_busy && (rq_count <= RQ_LIMIT);
  assign aw_ready = !wr_busy && !bq_full;
  assign w_ready  = wr_busy;

  assign ar_fire = ar_valid && ar_ready;
  assign aw_fire = aw_valid && aw_ready;
  assign w_fire  = w_valid && w_ready;
  assign r_pop   = r_valid && r_ready;
  assign b_pop   = b_valid && b_ready;

  axi_mem_rd_gen #(.ID_W(ID_W), .LEN_W(LEN_W), .WIDX_W(WIDX_W)) u_rd_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ar_fire),
    .start_widx (ar_widx),
    .start_id   (ar_id),
    .start_len  (ar_len),
    .busy       (rd_busy),
    .beat_valid (beat_valid),
    .beat_widx  (beat_widx),
    .beat_id    (beat_id),
    .beat_last  (beat_last)
  );

  axi_mem_wr_ctrl #(.ID_W(ID_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .NB(NB)) u_wr_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .aw_fire     (aw_fire),
    .aw_ofs      (aw_ofs),
    .aw_tag      (aw_id),
    .aw_beats_m1 (aw_len),
    .aw_lg_size  (aw_size),
    .w_fire      (w_fire),
    .w_end       (w_last),
    .busy        (wr_busy),
    .cur_widx    (wr_widx),
    .beat_mask   (wr_mask),
    .done        (wr_done),
    .done_id     (wr_done_id),
    .last_err    (wr_err)
  );

  assign lane_en = wr_mask & w_strb;

  always_ff @(posedge clk) begin
    if (w_fire) begin
      for (int b = 0; b < NB; b++)
        if (lane_en[b]) mem_q[wr_widx][b*8 +: 8] <= w_data[b*8 +: 8];
    end
  end

  assign rq_in = {beat_id, mem_q[beat_widx], beat_last};

  axi_mem_fifo #(.W(RQ_W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (beat_valid),
    .push_data (rq_in),
    .pop       (r_pop),
    .head      (rq_head),
    .empty     (rq_empty),
    .full      (rq_full),
    .count     (rq_count)
  );

  axi_mem_fifo #(.W(ID_W), .DEPTH(BQ_DEPTH)) u_bq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_done),
    .push_data (wr_done_id),
    .pop       (b_pop),
    .head      (bq_head),
    .empty     (bq_empty),
    .full      (bq_full),
    .count     (bq_count)
  );

  assign r_valid     = !rq_empty;
  assign r_id        = rq_empty ? '0 : rq_head[RQ_W-1 -: ID_W];
  assign r_data      = rq_empty ? '0 : rq_head[DATA_W:1];
  assign r_last      = !rq_empty && rq_head[0];
  assign r_resp      = RESP_OKAY;
  assign b_valid     = !bq_empty;
  assign b_id        = bq_empty ? '0 : bq_head;
  assign b_resp      = RESP_OKAY;
  assign wr_last_err = wr_err;
endmodule

// File: rtl/axi_mem_slave_chk.sv
module axi_mem_slave_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic              w_valid,
  input logic              w_ready,
  input logic              w_last,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data,
  input logic [ID_W-1:0]   r_id,
  input logic              r_last,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic              wr_last_err
);
  AST_AW_W_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(aw_ready && w_ready)); // R3

  AST_W_OPENS_AFTER_AW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_ready) |-> $past(aw_valid && aw_ready)); // R3

  AST_R_HELD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_id) && $stable(r_last))); // R6

  AST_B_HELD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id))); // R6

  AST_B_AFTER_W_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(w_valid && w_ready)); // R5

  AST_ERR_ONLY_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last_err |-> (w_valid && w_ready && !w_last)); // R5
endmodule

bind axi_mem_slave axi_mem_slave_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .aw_valid    (aw_valid),
  .aw_ready    (aw_ready),
  .w_valid     (w_valid),
  .w_ready     (w_ready),
  .w_last      (w_last),
  .r_valid     (r_valid),
  .r_ready     (r_ready),
  .r_data      (r_data),
  .r_id        (r_id),
  .r_last      (r_last),
  .b_valid     (b_valid),
  .b_ready     (b_ready),
  .b_id        (b_id),
  .wr_last_err (wr_last_err)
);

// File: tb/test_axi_mem_slave.sv
`timescale 1ns/1ps
module test_axi_mem_slave;
  localparam int          MEMB = 1024;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ar_valid, ar_ready;
  logic [31:0] ar_addr;
  logic [3:0]  ar_id, ar_len;
  logic        aw_valid, aw_ready;
  logic [31:0] aw_addr;
  logic [3:0]  aw_id, aw_len;
  logic [2:0]  aw_size;
  logic        w_valid, w_ready;
  logic [31:0] w_data;
  logic [3:0]  w_strb;
  logic        w_last;
  logic        r_valid, r_ready;
  logic [31:0] r_data;
  logic [3:0]  r_id;
  logic [1:0]  r_resp;
  logic        r_last;
  logic        b_valid, b_ready;
  logic [3:0]  b_id;
  logic [1:0]  b_resp;
  logic        wr_last_err;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mdl [MEMB];
  logic [31:0] q_data [$];
  logic [3:0]  q_id [$];
  bit          q_last [$];

  always #5 clk = ~clk;

  axi_mem_slave i_axi_mem_slave (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id), .aw_len(aw_len),
    .aw_size(aw_size),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_id(r_id), .r_resp(r_resp),
    .r_last(r_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .wr_last_err(wr_last_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] mdl_word(input int widx);
    int w;
    w = widx % (MEMB / 4);
    return {mdl[w*4+3], mdl[w*4+2], mdl[w*4+1], mdl[w*4]};
  endfunction

  // Push the model's expected read beats (R1, R2, R7 behaviour)
  task automatic expect_read(input logic [31:0] addr, input logic [3:0] id, input int len);
    int w0;
    w0 = int'(((addr - BASE) % MEMB) / 4);
    for (int i = 0; i <= len; i++) begin
      q_data.push_back(mdl_word(w0 + i));
      q_id.push_back(id);
      q_last.push_back(i == len);
    end
  endtask

  task automatic issue_ar(input logic [31:0] addr, input logic [3:0] id, input int len);
    @(negedge clk);
    ar_valid = 1'b1; ar_addr = addr; ar_id = id; ar_len = 4'(len);
    #1;
    while (!ar_ready) begin @(negedge clk); #1; end
    expect_read(addr, id, len);
    @(posedge clk);
    @(negedge clk);
    ar_valid = 1'b0;
  endtask

  task automatic drain_r(input int n, input string req);
    logic [31:0] ed; logic [3:0] ei; bit el;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      r_ready = 1'b1;
      #1;
      ed = q_data.pop_front(); ei = q_id.pop_front(); el = q_last.pop_front();
      chk(r_valid === 1'b1, {req, " r_valid"}, 64'(r_valid), 64'd1);
      chk(r_data === ed, {req, " r_data"}, 64'(r_data), 64'(ed));
      chk(r_id === ei, {req, " r_id"}, 64'(r_id), 64'(ei));
      chk(r_last === el, {req, " r_last"}, 64'(r_last), 64'(el));
      chk(r_resp === 2'b00, "R6 r_resp", 64'(r_resp), 64'd0);
      @(posedge clk);
    end
    @(negedge clk);
    r_ready = 1'b0;
    #1;
    chk(r_valid === 1'b0, "R9 r_valid after drain", 64'(r_valid), 64'd0);
    chk(r_data === 32'd0 && r_last === 1'b0 && r_id === 4'd0, "R9 idle r outputs zero",
        64'({r_id, r_last, r_data}), 64'd0);
  endtask

  task automatic do_write(input logic [31:0] addr, input logic [3:0] id, input int len,
                          input logic [2:0] size, input logic [31:0] seed, input logic [3:0] strb,
                          input bit bad_last, output bit saw_err);
    int a, sz;
    logic [31:0] d;
    saw_err = 1'b0;
    @(negedge clk);
    aw_valid = 1'b1; aw_addr = addr; aw_id = id; aw_len = 4'(len); aw_size = size;
    #1;
    while (!aw_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    a  = int'((addr - BASE) % MEMB);
    sz = 1 << size;
    for (int j = 0; j <= len; j++) begin
      @(negedge clk);
      aw_valid = 1'b0;
      d = seed + 32'h0101_0101 * j;
      w_valid = 1'b1; w_data = d; w_strb = strb; w_last = (j == len) && !bad_last;
      #1;
      while (!w_ready) begin @(negedge clk); #1; end
      if (wr_last_err) saw_err = 1'b1;
      for (int b = 0; b < 4; b++)
        if (strb[b] && b >= a % 4 && b < a % 4 + sz) mdl[(a / 4) * 4 + b] = d[b*8 +: 8];
      a = (a + sz) % MEMB;
      @(posedge clk);
    end
    @(negedge clk);
    w_valid = 1'b0; w_last = 1'b0;
  endtask

  task automatic expect_b(input logic [3:0] id, input string req);
    @(negedge clk);
    b_ready = 1'b1;
    #1;
    chk(b_valid === 1'b1, {req, " b_valid"}, 64'(b_valid), 64'd1);
    chk(b_id === id, {req, " b_id"}, 64'(b_id), 64'(id));
    chk(b_resp === 2'b00, "R6 b_resp", 64'(b_resp), 64'd0);
    @(posedge clk);
    @(negedge clk);
    b_ready = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(aw_ready === 1'b1, "R10 aw_ready", 64'(aw_ready), 64'd1);
    chk(ar_ready === 1'b1, "R10 ar_ready", 64'(ar_ready), 64'd1);
    chk(w_ready === 1'b0, "R10 w_ready", 64'(w_ready), 64'd0);
    chk(r_valid === 1'b0 && b_valid === 1'b0, "R10 queues empty", 64'({r_valid, b_valid}), 64'd0);
    chk(r_data === 32'd0 && b_id === 4'd0, "R9 idle outputs zero", 64'({b_id, r_data}), 64'd0);
  endtask

  task automatic t_full_burst();
    bit e;
    do_write(BASE + 32'h10, 4'h3, 3, 3'd2, 32'h1122_3344, 4'hF, 1'b0, e);
    chk(w_ready === 1'b0 && aw_ready === 1'b1, "R3 burst closed", 64'({w_ready, aw_ready}), 64'd1);
    chk(e === 1'b0, "R5 no error with w_last", 64'(e), 64'd0);
    expect_b(4'h3, "R5 burst completion");
    issue_ar(BASE + 32'h13, 4'h9, 3);   // R2 unaligned start aligned down
    drain_r(4, "R1 R2 four-beat read");
  endtask

  task automatic t_narrow();
    bit e;
    do_write(BASE + 32'h40, 4'h1, 3, 3'd2, 32'hA0A1_A2A3, 4'hF, 1'b0, e);
    expect_b(4'h1, "R5 prefill");
    do_write(BASE + 32'h41, 4'h2, 1, 3'd0, 32'h5566_7788, 4'hF, 1'b0, e);
    expect_b(4'h2, "R4 byte beats");
    do_write(BASE + 32'h46, 4'h3, 0, 3'd1, 32'hDEAD_BEEF, 4'hF, 1'b0, e);
    expect_b(4'h3, "R4 half beat");
    do_write(BASE + 32'h48, 4'h4, 0, 3'd2, 32'hCAFE_F00D, 4'b0101, 1'b0, e);
    expect_b(4'h4, "R4 sparse strobe");
    do_write(BASE + 32'h4E, 4'h5, 0, 3'd2, 32'h1357_9BDF, 4'hF, 1'b0, e);
    expect_b(4'h5, "R4 word beat at offset");
    issue_ar(BASE + 32'h40, 4'h6, 3);
    drain_r(4, "R4 masked lanes");
  endtask

  task automatic t_wrap();
    bit e;
    do_write(BASE + MEMB - 4, 4'h7, 1, 3'd2, 32'h0F0E_0D0C, 4'hF, 1'b0, e);
    expect_b(4'h7, "R7 wrapping write");
    issue_ar(BASE + 2 * MEMB + MEMB - 4, 4'h8, 1);
    drain_r(2, "R7 aliased wrapping read");
  endtask

  task automatic t_last_err();
    bit e;
    do_write(BASE + 32'h80, 4'hA, 1, 3'd2, 32'h2468_ACE0, 4'hF, 1'b1, e);
    chk(e === 1'b1, "R5 missing w_last flagged", 64'(e), 64'd1);
    expect_b(4'hA, "R5 completion despite missing w_last");
    @(negedge clk); #1;
    chk(wr_last_err === 1'b0, "R5 error is a pulse", 64'(wr_last_err), 64'd0);
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ar_valid = 1'b1; ar_addr = BASE + 32'h10 + 32'(4 * k); ar_id = 4'(k + 2); ar_len = 4'd0;
      #1;
      chk(ar_ready === 1'b1, "R1 single reads every cycle", 64'(ar_ready), 64'd1);
      expect_read(ar_addr, ar_id, 0);
      @(posedge clk);
    end
    @(negedge clk);
    ar_valid = 1'b0;
    drain_r(4, "R1 back-to-back singles");
  endtask

  task automatic t_read_backpressure();
    issue_ar(BASE + 32'h40, 4'hB, 15);
    issue_ar(BASE + 32'h10, 4'hC, 15);
    repeat (17) @(negedge clk);
    #1;
    chk(ar_ready === 1'b0, "R8 ar_ready low with full queue", 64'(ar_ready), 64'd0);
    chk(r_valid === 1'b1 && r_id === 4'hB, "R6 head held while stalled", 64'(r_id), 64'hB);
    drain_r(32, "R6 R8 thirty-two queued beats");
    chk(ar_ready === 1'b1, "R8 ar_ready back after drain", 64'(ar_ready), 64'd1);
  endtask

  task automatic t_b_backpressure();
    bit e;
    for (int k = 0; k < 4; k++)
      do_write(BASE + 32'h100 + 32'(4 * k), 4'(k + 1), 0, 3'd2, 32'h7700_0000 + 32'(k), 4'hF, 1'b0, e);
    #1;
    chk(aw_ready === 1'b0, "R3 aw_ready low with full completion queue", 64'(aw_ready), 64'd0);
    for (int k = 0; k < 4; k++) expect_b(4'(k + 1), "R6 completions in order");
    #1;
    chk(aw_ready === 1'b1 && b_valid === 1'b0, "R3 aw_ready after completions drain",
        64'({aw_ready, b_valid}), 64'h2);
    issue_ar(BASE + 32'h100, 4'hD, 3);
    drain_r(4, "R5 completed writes visible");
  endtask

  initial begin
    rst_n = 1'b0;
    ar_valid = 0; ar_addr = 0; ar_id = 0; ar_len = 0;
    aw_valid = 0; aw_addr = 0; aw_id = 0; aw_len = 0; aw_size = 0;
    w_valid = 0; w_data = 0; w_strb = 0; w_last = 0;
    r_ready = 0; b_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_burst();
    t_narrow();
    t_wrap();
    t_last_err();
    t_back_to_back();
    t_read_backpressure();
    t_b_backpressure();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule